// File: doc/BRIEF.md
# Serial CRC Signature Analyzer

This block condenses one serial stream of test-response bits into a short signature. It divides the polynomial that the stream forms by a fixed characteristic polynomial and keeps the remainder. A modular shift register with XOR gates placed between its stages holds that remainder. Each clock that carries a valid response bit moves the register on by one step. The first bit of the stream is the coefficient of the highest power.

A test runs as follows. A synchronous clear loads the seed into the register and zeroes the bit counter. The circuit under test then streams its response with a valid qualifier. Once the programmed number of bits has been taken in, the block raises `done`. It compares the remainder with a fault-free signature that is fixed at build time and raises either `pass` or `fail`. Later bits are ignored until the next clear. The width, polynomial taps, seed, golden signature and stream length are all parameters.

Top module: `crc_sig_analyzer`

## Requirements
- R1: While `rst_n` is low and after it is released, `signature` equals SEED (default all zeros) and `done`, `pass` and `fail` are low.
- R2: `signature[i]` holds coefficient X^i of the remainder. With the default taps (characteristic polynomial X^5 + X^3 + X + 1, TAPS = 5'b01011, bit i = coefficient of X^i), one accepted bit d gives s0' = d ^ s4, s1' = s0 ^ s4, s2' = s1, s3' = s2 ^ s4, s4' = s3.
- R3: The stream is taken with its highest-order coefficient first. The 8-bit stream 1,0,0,0,1,0,1,0 leaves `signature` = 5'b01101 (X0..X4 = 1,0,1,1,0).
- R4: A cycle with `bit_valid` low changes neither the signature nor the bit count.
- R5: `done` rises at the clock edge that accepts the N-th valid bit after a clear or reset (default N = 8), and not before.
- R6: `pass` is high exactly when `done` is high and `signature` equals GOLDEN (default 5'b01101). `fail` is high exactly when `done` is high and they differ. Both are low while `done` is low.
- R7: While `done` is high, valid bits leave `signature` and the verdict unchanged until the next clear.
- R8: `clear` loads SEED and zeroes the count in one cycle, and it takes priority over `bit_valid` in the same cycle.
- R9: An all-zero stream from the zero seed leaves the signature at zero, which gives `fail` against the default golden value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart: load the seed and zero the count |
| bit_valid | input | 1 | `bit_in` carries a response bit this cycle |
| bit_in | input | 1 | Serial response bit |
| signature | output | W | Current remainder, bit i = coefficient of X^i |
| done | output | 1 | N bits have been compacted |
| pass | output | 1 | Done and the remainder matches the golden value |
| fail | output | 1 | Done and the remainder differs from the golden value |

## Verification
A bench model performs polynomial long division on plain integers and is compared with the design on every clock. This exposes a tap placed at the wrong stage, which would drift away from the known remainder for the sample stream, and a bit order that is reversed. Streams are broken by idle gaps to catch a design that shifts on invalid cycles. Bits are sent past the N-th one to catch a register that keeps shifting after `done`, which would turn a pass into a fail. Clear is asserted in the middle of a stream, and also in the same cycle as a valid bit. A design that gives data priority over clear would start the next test from a non-seed value.

// File: rtl/crc_sig_pkg.sv
package crc_sig_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_PASS = 2'd1,
      VERDICT_FAIL = 2'd2
   } verdict_e;

   function automatic int unsigned count_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sig_lfsr_step.sv
module sig_lfsr_step #(
   parameter int unsigned W    = 5,
   parameter logic [W-1:0] TAPS = 5'b01011,
   parameter logic [W-1:0] SEED = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         advance,
   input  logic         bit_in,
   output logic [W-1:0] sig_q
);

   logic [W-1:0] sig_d;
   logic         msb;

   assign msb = sig_q[W-1];

   for (genvar i = 0; i < int'(W); i++) begin : g_stage
      logic feed;
      if (i == 0) begin : g_head
         assign feed = bit_in;
      end else begin : g_body
         assign feed = sig_q[i-1];
      end
      if (TAPS[i]) begin : g_tap
         assign sig_d[i] = feed ^ msb;
      end else begin : g_plain
         assign sig_d[i] = feed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q <= SEED;
      end else if (clear) begin
         sig_q <= SEED;
      end else if (advance) begin
         sig_q <= sig_d;
      end
   end

endmodule

// File: rtl/sig_bit_counter.sv
module sig_bit_counter #(
   parameter int unsigned N  = 8,
   parameter int unsigned CW = crc_sig_pkg::count_bits(N)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic valid,
   output logic advance,
   output logic full
);

   localparam logic [CW-1:0] LAST = CW'(N);

   logic [CW-1:0] cnt_q;

   assign full    = (cnt_q == LAST);
   assign advance = valid & ~clear & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (advance) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sig_compare.sv
module sig_compare #(
   parameter int unsigned W      = 5,
   parameter logic [W-1:0] GOLDEN = 5'b01101
) (
   input  logic                  done,
   input  logic [W-1:0]          sig,
   output crc_sig_pkg::verdict_e verdict
);

   import crc_sig_pkg::*;

   always_comb begin
      if (!done) begin
         verdict = VERDICT_NONE;
      end else if (sig == GOLDEN) begin
         verdict = VERDICT_PASS;
      end else begin
         verdict = VERDICT_FAIL;
      end
   end

endmodule

// File: rtl/crc_sig_analyzer.sv
module crc_sig_analyzer #(
   parameter int unsigned W      = 5,
   parameter logic [W-1:0] TAPS   = 5'b01011,
   parameter logic [W-1:0] SEED   = '0,
   parameter logic [W-1:0] GOLDEN = 5'b01101,
   parameter int unsigned N      = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         bit_valid,
   input  logic         bit_in,
   output logic [W-1:0] signature,
   output logic         done,
   output logic         pass,
   output logic         fail
);

   import crc_sig_pkg::*;

   localparam int unsigned CW = count_bits(N);

   if (W < 2) begin : g_bad_width
      $error("crc_sig_analyzer: W must be at least 2");
   end
   if (N < 1) begin : g_bad_length
      $error("crc_sig_analyzer: N must be at least 1");
   end
   if (!TAPS[0]) begin : g_bad_taps
      $error("crc_sig_analyzer: TAPS bit 0 must be set for a valid polynomial");
   end

   logic     step;
   verdict_e verdict;

   sig_bit_counter #(.N(N), .CW(CW)) u_count (
      .clk(clk), .rst_n(rst_n), .clear(clear), .valid(bit_valid),
      .advance(step), .full(done)
   );

   sig_lfsr_step #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .clear(clear), .advance(step),
      .bit_in(bit_in), .sig_q(signature)
   );

   sig_compare #(.W(W), .GOLDEN(GOLDEN)) u_cmp (
      .done(done), .sig(signature), .verdict(verdict)
   );

   assign pass = (verdict == VERDICT_PASS);
   assign fail = (verdict == VERDICT_FAIL);

endmodule

module crc_sig_analyzer_chk #(
   parameter int unsigned W    = 5,
   parameter logic [W-1:0] SEED = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clear,
   input logic         bit_valid,
   input logic [W-1:0] signature,
   input logic         done,
   input logic         pass,
   input logic         fail
);

   AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (signature == SEED) && !done); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !clear) |=> $stable(signature)); // R4

   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clear) |=> done && $stable(signature)); // R7

   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail)); // R6

   AST_VERDICT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || fail) |-> done); // R6

   AST_DONE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(bit_valid) && !$past(clear)); // R5

endmodule

bind crc_sig_analyzer crc_sig_analyzer_chk #(.W(W), .SEED(SEED)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
   .signature(signature), .done(done), .pass(pass), .fail(fail)
);

// File: tb/crc_sig_analyzer_tb.sv
module crc_sig_analyzer_tb;

   localparam int W      = 5;
   localparam int N      = 8;
   localparam int GOLD   = 13;   // 5'b01101
   localparam int DIVISOR = 43;  // X^5 + X^3 + X + 1

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clear = 1'b0;
   logic         bit_valid = 1'b0;
   logic         bit_in = 1'b0;
   logic [W-1:0] signature;
   logic         done, pass, fail;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int m_rem = 0;
   int m_cnt = 0;
   bit live_check = 1'b0;
   int lcg = 12345;

   always #2.5 clk = ~clk;

   crc_sig_analyzer u_dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
      .bit_in(bit_in), .signature(signature), .done(done), .pass(pass), .fail(fail)
   );

   // behavioural model: polynomial long division on an integer
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0; m_cnt = 0;
      end else if (clear) begin
         m_rem = 0; m_cnt = 0;
      end else if (bit_valid && m_cnt < N) begin
         m_rem = (m_rem << 1) | int'(bit_in);
         if ((m_rem & 32) != 0) m_rem = m_rem ^ DIVISOR;
         m_cnt = m_cnt + 1;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (live_check) begin
         check("R2 signature", int'(signature), m_rem);
         check("R5 done", int'(done), int'(m_cnt == N));
         check("R6 pass", int'(pass), int'(m_cnt == N && m_rem == GOLD));
         check("R6 fail", int'(fail), int'(m_cnt == N && m_rem != GOLD));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++; tests++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic drive(input bit c, input bit v, input bit d);
      @(negedge clk);
      #1;
      clear = c; bit_valid = v; bit_in = d;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit gaps);
      for (int i = 7; i >= 0; i--) begin
         drive(1'b0, 1'b1, b[i]);
         if (gaps && (i % 3 == 0)) drive(1'b0, 1'b0, ~b[i]);
      end
      drive(1'b0, 1'b0, 1'b0);
   endtask

   task automatic wait_sample();
      @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 sig", int'(signature), 0);
      check("R1 done", int'(done), 0);
      check("R1 verdict", int'(pass | fail), 0);
      rst_n = 1'b1;
      wait_sample();
      check("R1 sig after release", int'(signature), 0);
      live_check = 1'b1;

      // R3 and R4: sample stream with idle gaps carrying junk data
      send_byte(8'b1000_1010, 1'b1);
      wait_sample();
      check("R3 sample signature", int'(signature), 13);
      check("R3 pass", int'(pass), 1);
      check("R5 done after 8", int'(done), 1);

      // R7: extra valid bits after done are ignored
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b0);
      wait_sample();
      check("R7 frozen signature", int'(signature), 13);
      check("R7 pass held", int'(pass), 1);

      // R8: clear together with a valid bit
      drive(1'b1, 1'b1, 1'b1);
      drive(1'b0, 1'b0, 1'b0);
      wait_sample();
      check("R8 seed after clear", int'(signature), 0);
      check("R8 done cleared", int'(done), 0);

      // R9: all-zero stream
      send_byte(8'h00, 1'b0);
      wait_sample();
      check("R9 zero signature", int'(signature), 0);
      check("R9 fail", int'(fail), 1);

      // all-ones stream, model-derived expectation
      drive(1'b1, 1'b0, 1'b0);
      send_byte(8'hFF, 1'b1);
      wait_sample();
      check("R6 ones fail", int'(fail), int'(m_rem != GOLD));

      // R8: clear in the middle of a stream, then the sample stream again
      drive(1'b1, 1'b0, 1'b0);
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b0);
      send_byte(8'b1000_1010, 1'b0);
      wait_sample();
      check("R8 restart gives sample signature", int'(signature), 13);

      // pseudo-random streams
      for (int k = 0; k < 20; k++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         drive(1'b1, 1'b0, 1'b0);
         send_byte(lcg[15:8], k[0]);
      end
      wait_sample();
      live_check = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule